// File: doc/BRIEF.md
# Parallel-Port Burst Transfer Engine

This block sits on the host side of a parallel-port link to a disk adapter. It moves one burst of bytes between a byte stream and the adapter's data register. It drives the eight data lines, the data-line output enable and an eight-bit control code. It samples the status lines and the data lines.

A burst is requested with a one-cycle start pulse together with a direction, a transfer mode and a byte count. The engine first selects the adapter register with a fixed handshake on the control lines. It then runs the per-byte pattern for the chosen mode and finally steps through the closing control codes. Read bytes are offered on a valid/ready stream. Write bytes are taken from a valid/ready stream. Each control step lasts one clock cycle, and the engine waits at a fixed step whenever a stream is not ready.

Top module: `pp_burst_engine`

## Requirements
- R1: Out of reset and whenever it is idle, the engine shows control 0x04 with the data-line output enable high. In that state busy, done, rd_valid and wr_ready are all low, and the data lines read 0x00 after reset.
- R2: Every accepted burst first runs eight steps with the register address on the data lines and the enable high. The control codes of these steps are 0x04, 0x0C, 0x0E, 0x0E, 0x0C, 0x04, 0x04, 0x04. The address is 0x08 for writes and nibble reads, and 0xC8 for byte-wide reads.
- R3: In a nibble read (dir_rd_i=1, mode_i=0), each byte takes two steps. The first shows control 0x06 and samples status bits 7:4 as the low nibble. The second shows control 0x04 and samples status bits 7:4 as the high nibble.
- R4: In a byte-wide read (dir_rd_i=1, mode_i=1), one step drives 0xFF with the enable high. The enable then stays low while the bytes are sampled. The control code alternates per byte, starting at 0xA6 and then 0xA4, and the data lines are sampled at the end of each such step.
- R5: A byte-wide read closes with control 0xAC, then 0xA4 with the enable low, then 0x04 with the enable high again.
- R6: A write (dir_rd_i=0, mode_i 0 to 2) shows control 0x05 after the select steps. For each byte it puts the byte on the data lines with control 0x05, then shows 0x07, then 0x05 again. The burst ends with control 0x04.
- R7: rd_valid_o is high only in a read hand-off step. While rd_ready_i is low, the byte and every output line stay unchanged.
- R8: wr_ready_o is high only while control is 0x05 and bytes remain to be written. While wr_valid_i is low, the engine holds at that step.
- R9: Exactly count_i bytes are moved. done_o is high for exactly the one cycle in which the final 0x04 step is shown, and busy_o is high from the first select step through that cycle.
- R10: A start pulse has no effect in any of these cases: while busy, with a count of zero, with mode_i=3, or with mode_i=2 and dir_rd_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst request pulse |
| dir_rd_i | input | 1 | 1 = read from adapter, 0 = write to adapter |
| mode_i | input | 2 | 0 nibble, 1 byte-wide, 2 wide write only |
| count_i | input | CNT_W | Bytes in the burst (1 or more) |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | High during the final step of a burst |
| pp_data_o | output | 8 | Data lines, driven value |
| pp_data_oe_o | output | 1 | Data-line output enable |
| pp_ctrl_o | output | 8 | Control code |
| pp_data_i | input | 8 | Data lines, sampled value |
| pp_status_i | input | 8 | Status lines |
| rd_valid_o | output | 1 | Read byte available |
| rd_data_o | output | 8 | Read byte |
| rd_ready_i | input | 1 | Read byte accepted |
| wr_valid_i | input | 1 | Write byte offered |
| wr_data_i | input | 8 | Write byte |
| wr_ready_o | output | 1 | Write byte taken |

## Verification
The bench builds the engine with a 6-bit count. This makes the largest legal burst, 63 bytes, short enough to run in full with random stalls on both streams, and it exercises the counter's all-ones load. The other address and offset parameters keep their defaults. With those defaults the bench can predict the select address, and the control alternation can be checked across both odd and even byte counts.

// File: rtl/pp_burst_pkg.sv
package pp_burst_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_WHOLD, S_WSET, S_WSTB,
    S_NLO, S_NHI, S_REL, S_BRD, S_PUSH,
    S_TRM0, S_TRM1, S_FIN
  } pp_state_e;

  typedef enum logic [1:0] { K_WR, K_NIB, K_BYTE } pp_kind_e;

  localparam logic [1:0] MODE_NIB   = 2'd0;
  localparam logic [1:0] MODE_BYTE  = 2'd1;
  localparam logic [1:0] MODE_WWIDE = 2'd2;

  localparam logic [7:0] CTL_REST    = 8'h04;
  localparam logic [7:0] CTL_WR_IDLE = 8'h05;
  localparam logic [7:0] CTL_NIB_LO  = 8'h06;
  localparam logic [7:0] CTL_WR_STB  = 8'h07;
  localparam logic [7:0] CTL_TRM0    = 8'hAC;
  localparam logic [7:0] CTL_TRM1    = 8'hA4;
  localparam logic [7:0] BUS_FREE    = 8'hFF;

  // control code of select step idx
  function automatic logic [7:0] sel_ctrl(input logic [2:0] idx);
    case (idx)
      3'd1, 3'd4: sel_ctrl = 8'h0C;
      3'd2, 3'd3: sel_ctrl = 8'h0E;
      default:    sel_ctrl = 8'h04;
    endcase
  endfunction

  // byte-wide read strobe code by phase
  function automatic logic [7:0] byte_rd_ctrl(input logic ph);
    byte_rd_ctrl = ph ? 8'hA4 : 8'hA6;
  endfunction

  // two status samples into one byte, each carrying a nibble in bits 7:4
  function automatic logic [7:0] join_nibbles(input logic [7:0] lo_s,
                                              input logic [7:0] hi_s);
    join_nibbles = {hi_s[7:4], lo_s[7:4]};
  endfunction

  function automatic logic start_legal(input logic rd, input logic [1:0] md,
                                       input logic nonzero);
    start_legal = nonzero && (rd ? (md == MODE_NIB || md == MODE_BYTE)
                                 : (md != 2'd3));
  endfunction

endpackage

// File: rtl/pp_burst_count.sv
module pp_burst_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             empty_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (load_i) rem_q <= load_val_i;
    else if (dec_i)  rem_q <= rem_q - ONE;
  end

  assign empty_o = (rem_q == '0);
  assign last_o  = (rem_q == ONE);

  // R9: never count below zero
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> !empty_o);
endmodule

// File: rtl/pp_burst_capture.sv
module pp_burst_capture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_lo_i,
  input  logic       cap_hi_i,
  input  logic       cap_byte_i,
  input  logic [7:0] status_i,
  input  logic [7:0] data_i,
  output logic [7:0] byte_o
);
  import pp_burst_pkg::*;

  logic [7:0] lo_q, byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      byte_q <= '0;
    end else begin
      if (cap_lo_i)   lo_q   <= status_i;
      if (cap_hi_i)   byte_q <= join_nibbles(lo_q, status_i);
      if (cap_byte_i) byte_q <= data_i;
    end
  end

  assign byte_o = byte_q;

  // R3: at most one sampling event per cycle
  p_one_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_lo_i, cap_hi_i, cap_byte_i}));
endmodule

// File: rtl/pp_burst_fsm.sv
module pp_burst_fsm #(
  parameter logic [7:0] DATA_REG    = 8'h08,
  parameter logic [7:0] WIDE_RD_OFS = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic       dir_rd_i,
  input  logic [1:0] mode_i,
  input  logic       rem_empty_i,
  input  logic       rem_last_i,
  input  logic       rd_ready_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] data_o,
  output logic       oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       rd_valid_o,
  output logic       wr_ready_o,
  output logic       cnt_dec_o,
  output logic       cap_lo_o,
  output logic       cap_hi_o,
  output logic       cap_byte_o
);
  import pp_burst_pkg::*;

  localparam logic [7:0] ADDR_WIDE = DATA_REG + WIDE_RD_OFS;
  localparam logic [2:0] SEL_LAST  = 3'd7;

  pp_state_e  st_q, nst;
  pp_kind_e   kind_q, nkind;
  logic [7:0] ctrl_q, nctrl, data_q, ndata;
  logic       oe_q, noe, ph_q, nph;
  logic [2:0] idx_q, nidx;

  // named events for assertions and wiring
  logic rd_take, wr_take;
  assign rd_valid_o = (st_q == S_PUSH);
  assign wr_ready_o = (st_q == S_WHOLD) && !rem_empty_i;
  assign rd_take    = rd_valid_o && rd_ready_i;
  assign wr_take    = wr_ready_o && wr_valid_i;
  assign cnt_dec_o  = rd_take || wr_take;

  always_comb begin
    nst = st_q; nkind = kind_q; nctrl = ctrl_q; ndata = data_q;
    noe = oe_q; nph = ph_q; nidx = idx_q;
    cap_lo_o = 1'b0; cap_hi_o = 1'b0; cap_byte_o = 1'b0;
    case (st_q)
      S_IDLE: if (go_i) begin
        nst = S_SEL; nidx = 3'd0; nctrl = sel_ctrl(3'd0); noe = 1'b1; nph = 1'b0;
        if (!dir_rd_i) nkind = K_WR;
        else if (mode_i == MODE_BYTE) nkind = K_BYTE;
        else nkind = K_NIB;
        ndata = (dir_rd_i && mode_i == MODE_BYTE) ? ADDR_WIDE : DATA_REG;
      end
      S_SEL: if (idx_q == SEL_LAST) begin
        case (kind_q)
          K_WR:    begin nst = S_WHOLD; nctrl = CTL_WR_IDLE; end
          K_NIB:   begin nst = S_NLO;   nctrl = CTL_NIB_LO;  end
          default: begin nst = S_REL;   nctrl = CTL_REST; ndata = BUS_FREE; end
        endcase
      end else begin
        nidx  = 3'(idx_q + 3'd1);
        nctrl = sel_ctrl(3'(idx_q + 3'd1));
      end
      S_WHOLD: begin
        if (rem_empty_i) begin
          nst = S_FIN; nctrl = CTL_REST;
        end else if (wr_valid_i) begin
          nst = S_WSET; ndata = wr_data_i;
        end
      end
      S_WSET: begin nst = S_WSTB;  nctrl = CTL_WR_STB;  end
      S_WSTB: begin nst = S_WHOLD; nctrl = CTL_WR_IDLE; end
      S_NLO:  begin nst = S_NHI; nctrl = CTL_REST; cap_lo_o = 1'b1; end
      S_NHI:  begin nst = S_PUSH; cap_hi_o = 1'b1; end
      S_REL:  begin nst = S_BRD; nctrl = byte_rd_ctrl(1'b0); noe = 1'b0; end
      S_BRD:  begin nst = S_PUSH; cap_byte_o = 1'b1; nph = !ph_q; end
      S_PUSH: if (rd_ready_i) begin
        if (rem_last_i) begin
          if (kind_q == K_BYTE) begin nst = S_TRM0; nctrl = CTL_TRM0; end
          else begin nst = S_FIN; nctrl = CTL_REST; end
        end else if (kind_q == K_BYTE) begin
          nst = S_BRD; nctrl = byte_rd_ctrl(ph_q);
        end else begin
          nst = S_NLO; nctrl = CTL_NIB_LO;
        end
      end
      S_TRM0: begin nst = S_TRM1; nctrl = CTL_TRM1; end
      S_TRM1: begin nst = S_FIN; nctrl = CTL_REST; noe = 1'b1; end
      S_FIN:  nst = S_IDLE;
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; kind_q <= K_WR; ctrl_q <= CTL_REST; data_q <= 8'h00;
      oe_q <= 1'b1; ph_q <= 1'b0; idx_q <= 3'd0;
    end else begin
      st_q <= nst; kind_q <= nkind; ctrl_q <= nctrl; data_q <= ndata;
      oe_q <= noe; ph_q <= nph; idx_q <= nidx;
    end
  end

  assign ctrl_o = ctrl_q;
  assign data_o = data_q;
  assign oe_o   = oe_q;
  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_FIN);

  // R2: address held across the select steps
  p_sel_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SEL && $past(st_q) == S_SEL) |-> $stable(data_q) && oe_q);
  // R4: enable low while byte-wide strobe codes are shown
  p_oe_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == 8'hA6 || ctrl_q == CTL_TRM0) |-> !oe_q);
  // R5: closing order
  p_term_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q == CTL_TRM0 |=> ctrl_q == CTL_TRM1);
  p_term_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == CTL_TRM1 && $past(ctrl_q) == CTL_TRM0) |=> ctrl_q == CTL_REST && oe_q);
  // R6: strobe returns to 0x05 with the byte unchanged
  p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q == CTL_WR_STB |=> ctrl_q == CTL_WR_IDLE && $stable(data_q));
  // R8: write byte only taken at the 0x05 step
  p_wr_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready_o |-> ctrl_q == CTL_WR_IDLE && oe_q);
endmodule

// File: rtl/pp_burst_engine.sv
module pp_burst_engine #(
  parameter int         CNT_W       = 16,
  parameter logic [7:0] DATA_REG    = 8'h08,
  parameter logic [7:0] WIDE_RD_OFS = 8'hC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dir_rd_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       pp_data_o,
  output logic             pp_data_oe_o,
  output logic [7:0]       pp_ctrl_o,
  input  logic [7:0]       pp_data_i,
  input  logic [7:0]       pp_status_i,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  input  logic             rd_ready_i,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_ready_o
);
  import pp_burst_pkg::*;

  logic go, rem_empty, rem_last, cnt_dec, cap_lo, cap_hi, cap_byte;

  // R10: start accepted only when idle and legal
  assign go = start_i && !busy_o && start_legal(dir_rd_i, mode_i, count_i != '0);

  pp_burst_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load_i(go), .load_val_i(count_i),
    .dec_i(cnt_dec), .empty_o(rem_empty), .last_o(rem_last)
  );

  pp_burst_capture u_capture (
    .clk(clk), .rst_n(rst_n), .cap_lo_i(cap_lo), .cap_hi_i(cap_hi),
    .cap_byte_i(cap_byte), .status_i(pp_status_i), .data_i(pp_data_i),
    .byte_o(rd_data_o)
  );

  pp_burst_fsm #(.DATA_REG(DATA_REG), .WIDE_RD_OFS(WIDE_RD_OFS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go_i(go), .dir_rd_i(dir_rd_i), .mode_i(mode_i),
    .rem_empty_i(rem_empty), .rem_last_i(rem_last), .rd_ready_i(rd_ready_i),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .ctrl_o(pp_ctrl_o),
    .data_o(pp_data_o), .oe_o(pp_data_oe_o), .busy_o(busy_o), .done_o(done_o),
    .rd_valid_o(rd_valid_o), .wr_ready_o(wr_ready_o), .cnt_dec_o(cnt_dec),
    .cap_lo_o(cap_lo), .cap_hi_o(cap_hi), .cap_byte_o(cap_byte)
  );

  // R1: idle shows the rest code with the bus driven
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> pp_ctrl_o == 8'h04 && pp_data_oe_o && !rd_valid_o && !wr_ready_o);
  // R7: stalled read hand-off freezes byte and lines
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> rd_valid_o && $stable(rd_data_o)
                                    && $stable(pp_ctrl_o) && $stable(pp_data_oe_o));
  // R9: done is a single cycle followed by idle
  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o && !done_o);
endmodule

// File: tb/pp_burst_engine_test.sv
module pp_burst_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CNT_W   = 6;
  localparam int WD_LIMIT   = 150000;

  localparam int KP = 0, KLO = 1, KHI = 2, KCB = 3, KPUSH = 4, KWW = 5, KDONE = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, dir_rd_i = 0, rd_ready_i = 0, wr_valid_i = 0;
  logic [1:0] mode_i = 0;
  logic [TB_CNT_W-1:0] count_i = 0;
  logic [7:0] pp_data_i = 0, pp_status_i = 0, wr_data_i = 0;
  logic busy_o, done_o, pp_data_oe_o, rd_valid_o, wr_ready_o;
  logic [7:0] pp_data_o, pp_ctrl_o, rd_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_burst_engine #(.CNT_W(TB_CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_rd_i(dir_rd_i),
    .mode_i(mode_i), .count_i(count_i), .busy_o(busy_o), .done_o(done_o),
    .pp_data_o(pp_data_o), .pp_data_oe_o(pp_data_oe_o), .pp_ctrl_o(pp_ctrl_o),
    .pp_data_i(pp_data_i), .pp_status_i(pp_status_i), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .rd_ready_i(rd_ready_i), .wr_valid_i(wr_valid_i),
    .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o)
  );

  typedef struct {
    logic [7:0] ctrl;
    logic [7:0] data;
    bit         use_wb;
    bit         oe;
    int         kind;
    int         req;
  } ent_t;

  ent_t q[$];
  int compared = 0, mismatched = 0, cycles = 0, idle_req = 1;
  int got_rd = 0, got_wr = 0;
  bit stall = 0, timed_out = 0;
  logic [7:0] last_data = 8'h00, wb = 8'h00, lo_n = 8'h00, asm_b = 8'h00;

  function automatic ent_t mk(logic [7:0] c, logic [7:0] d, bit u, bit o, int k, int r);
    ent_t e; e.ctrl = c; e.data = d; e.use_wb = u; e.oe = o; e.kind = k; e.req = r;
    return e;
  endfunction

  // expected step list for an accepted burst
  task automatic plan(bit rd, logic [1:0] md, int n);
    logic [7:0] sel [8] = '{8'h04, 8'h0C, 8'h0E, 8'h0E, 8'h0C, 8'h04, 8'h04, 8'h04};
    logic [7:0] adr = (rd && md == 2'd1) ? 8'hC8 : 8'h08;
    for (int i = 0; i < 8; i++) q.push_back(mk(sel[i], adr, 0, 1, KP, 2)); // R2
    if (!rd) begin // R6, R8
      q.push_back(mk(8'h05, adr, 0, 1, KWW, 8));
      for (int i = 0; i < n; i++) begin
        q.push_back(mk(8'h05, 0, 1, 1, KP, 6));
        q.push_back(mk(8'h07, 0, 1, 1, KP, 6));
        q.push_back(mk(8'h05, 0, 1, 1, (i < n-1) ? KWW : KP, 6));
      end
      q.push_back(mk(8'h04, 0, 1, 1, KDONE, 9));
    end else if (md == 2'd0) begin // R3
      for (int i = 0; i < n; i++) begin
        q.push_back(mk(8'h06, adr, 0, 1, KLO, 3));
        q.push_back(mk(8'h04, adr, 0, 1, KHI, 3));
        q.push_back(mk(8'h04, adr, 0, 1, KPUSH, 7));
      end
      q.push_back(mk(8'h04, adr, 0, 1, KDONE, 9));
    end else begin // R4, R5
      q.push_back(mk(8'h04, 8'hFF, 0, 1, KP, 4));
      for (int i = 0; i < n; i++) begin
        q.push_back(mk((i % 2) ? 8'hA4 : 8'hA6, 8'hFF, 0, 0, KCB, 4));
        q.push_back(mk((i % 2) ? 8'hA4 : 8'hA6, 8'hFF, 0, 0, KPUSH, 7));
      end
      q.push_back(mk(8'hAC, 8'hFF, 0, 0, KP, 5));
      q.push_back(mk(8'hA4, 8'hFF, 0, 0, KP, 5));
      q.push_back(mk(8'h04, 8'hFF, 0, 1, KDONE, 9));
    end
  endtask

  task automatic tick(bit st, bit dr, logic [1:0] md, int cnt);
    ent_t e;
    bit idle_now, ok;
    logic [7:0] xd;
    @(negedge clk);
    cycles++;
    if (cycles > WD_LIMIT) timed_out = 1;
    pp_status_i = 8'($urandom);
    pp_data_i   = 8'($urandom);
    wr_data_i   = 8'($urandom);
    rd_ready_i  = stall ? ($urandom % 3 != 0) : 1'b1;
    wr_valid_i  = stall ? ($urandom % 3 != 0) : 1'b1;
    start_i = st; dir_rd_i = dr; mode_i = md; count_i = TB_CNT_W'(cnt);
    idle_now = (q.size() == 0);
    if (idle_now) e = mk(8'h04, last_data, 0, 1, KP, idle_req);
    else e = q[0];
    xd = e.use_wb ? wb : e.data;
    ok = (pp_ctrl_o === e.ctrl) && (pp_data_o === xd) && (pp_data_oe_o === e.oe)
      && (busy_o === !idle_now) && (done_o === (e.kind == KDONE))
      && (rd_valid_o === (e.kind == KPUSH)) && (wr_ready_o === (e.kind == KWW));
    if (e.kind == KPUSH && rd_data_o !== asm_b) ok = 0;
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL R%0d: got ctrl=%h data=%h oe=%b busy=%b done=%b rv=%b rd=%h wr=%b exp ctrl=%h data=%h oe=%b busy=%b kind=%0d rd=%h",
        e.req, pp_ctrl_o, pp_data_o, pp_data_oe_o, busy_o, done_o, rd_valid_o, rd_data_o,
        wr_ready_o, e.ctrl, xd, e.oe, !idle_now, e.kind, asm_b);
    end
    if (!idle_now) begin
      last_data = xd;
      case (e.kind)
        KLO:   begin lo_n = pp_status_i; void'(q.pop_front()); end
        KHI:   begin asm_b = {pp_status_i[7:4], lo_n[7:4]}; void'(q.pop_front()); end
        KCB:   begin asm_b = pp_data_i; void'(q.pop_front()); end
        KPUSH: if (rd_ready_i) begin got_rd++; void'(q.pop_front()); end
        KWW:   if (wr_valid_i) begin wb = wr_data_i; got_wr++; void'(q.pop_front()); end
        default: void'(q.pop_front());
      endcase
    end
    // R10: legality as stated in the requirements
    if (st && idle_now && cnt != 0 && (dr ? (md <= 2'd1) : (md <= 2'd2))) plan(dr, md, cnt);
  endtask

  task automatic check(bit c, int r, int got, int exp);
    compared++;
    if (!c) begin
      mismatched++;
      $display("FAIL R%0d: got %0d expected %0d", r, got, exp);
    end
  endtask

  task automatic burst(bit dr, logic [1:0] md, int n, bit stl);
    stall = stl; got_rd = 0; got_wr = 0;
    tick(1, dr, md, n);
    while (q.size() != 0 && !timed_out) tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    // R9: byte count moved
    check((dr ? got_rd : got_wr) == n, 9, dr ? got_rd : got_wr, n);
  endtask

  initial begin
    repeat (3) tick(0, 0, 0, 0);       // R1 during reset
    rst_n = 1'b1;
    repeat (2) tick(0, 0, 0, 0);       // R1 after reset
    burst(0, 2'd0, 1, 0);              // R6 single write
    burst(0, 2'd0, 5, 1);              // R6 R8 with gaps
    burst(0, 2'd1, 3, 0);              // R6 in mode 1
    burst(0, 2'd2, 4, 1);              // R6 in mode 2
    burst(1, 2'd0, 1, 0);              // R3
    burst(1, 2'd0, 4, 1);              // R3 R7
    burst(1, 2'd1, 1, 0);              // R4 R5
    burst(1, 2'd1, 2, 1);              // R4 alternation
    burst(1, 2'd1, 7, 1);              // R4 R7 odd count
    burst(1, 2'd1, 63, 1);             // R9 all-ones count
    idle_req = 10;                     // R10 ignored starts
    tick(1, 1, 2'd3, 5); repeat (3) tick(0, 0, 0, 0);
    tick(1, 1, 2'd2, 5); repeat (3) tick(0, 0, 0, 0);
    tick(1, 0, 2'd3, 5); repeat (3) tick(0, 0, 0, 0);
    tick(1, 0, 2'd0, 0); repeat (3) tick(0, 0, 0, 0);
    stall = 0; got_wr = 0;
    tick(1, 0, 2'd0, 3);               // R10 start while busy
    tick(0, 0, 0, 0); tick(0, 0, 0, 0);
    tick(1, 1, 2'd1, 9);
    while (q.size() != 0 && !timed_out) tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    check(got_wr == 3 && got_rd == 63, 10, got_wr, 3);
    if (timed_out) begin
      mismatched++;
      $display("FAIL R9: watchdog expired after %0d cycles, expected idle", cycles);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule